// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block is the status and interrupt side of an SPI controller whose transmit and receive FIFOs hold 32-bit words. The datapath supplies the live byte occupancy of each FIFO. The block folds those counts into one status word. Next to the counts sit two sticky flags: one for "receive FIFO holds data" and one for "transmit FIFO has room". A single level interrupt is raised when any flag that software has unmasked is set.

The block also holds the global mode register. That register carries the controller enable, an internal loopback select and two FIFO threshold fields, which are driven out to the datapath. Clearing the enable asks the datapath to flush both FIFOs. While the enable is low, the reported counts read as zero and neither flag condition is true.

Software reaches three words through a small register port: mode, event and mask. Reads are combinational and writes take effect at the clock edge. Software acknowledges an event by writing the value it read back to the event word. A 1 clears a flag only once the condition behind that flag has gone away.

Top module: `spi_evt_irq_unit`

## Requirements
- R1: After reset, mode reads 0x00000403: enable 0, loopback 0, transmit threshold 4, receive threshold 3. Mask reads 0, event reads 0 and the interrupt is low.
- R2: In the mode word (address 0), bit 31 is enable, bit 30 is loopback, bits 13:8 are the transmit threshold and bits 5:0 are the receive threshold. A write updates all four fields and the matching outputs. The other bits read 0.
- R3: While enabled, event word (address 1) bits 29:24 show the receive byte count and bits 21:16 show the transmit byte count. Both are taken live from the inputs.
- R4: While the enable is 0, the flush output is high and both count fields read zero.
- R5: Bit 9 (receive-not-empty) becomes set one cycle after the block is enabled with a nonzero receive count. Bit 8 (transmit-not-full) becomes set one cycle after the block is enabled with a transmit count below the capacity, which is 4 × FIFO depth = 32 bytes by default.
- R6: Writing 1 to an event flag clears it when its condition is false. Writing 0 leaves it unchanged.
- R7: Writing 1 to an event flag whose condition still holds leaves it set.
- R8: Mask (address 2) bits 9 and 8 are read/write and enable the matching flags. All other mask bits read 0.
- R9: The interrupt goes high one cycle after a set flag and its mask bit are both 1. It goes low one cycle after no masked flag remains. With the mask at 0 it stays low.
- R10: A write to the event word leaves the count fields unchanged. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Word select: 0 mode, 1 event, 2 mask |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| rx_byte_cnt | input | 6 | Receive FIFO occupancy in bytes |
| tx_byte_cnt | input | 6 | Transmit FIFO occupancy in bytes |
| ctrl_en | output | 1 | Controller enable |
| loopback | output | 1 | Internal loopback select |
| tx_thresh | output | 6 | Transmit threshold |
| rx_thresh | output | 6 | Receive threshold |
| fifo_flush | output | 1 | Flush request to both FIFOs |
| irq | output | 1 | Registered interrupt |

## Verification
The assertions assume that the occupancy inputs never exceed the FIFO capacity. They also assume that the inputs change only away from the rising edge, so a count seen by the flag logic is the count present in the cycle before. The stimulus changes every input on the falling edge. It keeps both byte counts between 0 and 32, and exercises the full transmit FIFO only at exactly 32. The stimulus also disables the controller before each clear so that flags can drop.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_EVT  = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;

  localparam int WORD_W      = 32;
  localparam int FIELD_W     = 6;
  localparam int RXCNT_LSB   = 24;
  localparam int TXCNT_LSB   = 16;
  localparam int FLAG_LSB    = 8;
  localparam int NFLAG       = 2;
  localparam int FLAG_NF     = 0;
  localparam int FLAG_NE     = 1;
  localparam int MODE_EN_BIT = 31;
  localparam int MODE_LB_BIT = 30;
  localparam int TXTHR_LSB   = 8;
  localparam int RXTHR_LSB   = 0;
endpackage

// File: rtl/spi_mode_regs.sv
module spi_mode_regs
  import spi_evt_pkg::*;
#(
  parameter int THR_W     = 6,
  parameter int TXTHR_RST = 4,
  parameter int RXTHR_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             en_in,
  input  logic             lb_in,
  input  logic [THR_W-1:0] txthr_in,
  input  logic [THR_W-1:0] rxthr_in,
  output logic             en_q,
  output logic             lb_q,
  output logic [THR_W-1:0] txthr_q,
  output logic [THR_W-1:0] rxthr_q
);
  logic             en_d, lb_d;
  logic [THR_W-1:0] txthr_d, rxthr_d;

  always_comb begin
    en_d    = en_q;
    lb_d    = lb_q;
    txthr_d = txthr_q;
    rxthr_d = rxthr_q;
    if (wr_en) begin
      en_d    = en_in;
      lb_d    = lb_in;
      txthr_d = txthr_in;
      rxthr_d = rxthr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      lb_q    <= 1'b0;
      txthr_q <= THR_W'(TXTHR_RST);
      rxthr_q <= THR_W'(RXTHR_RST);
    end else begin
      en_q    <= en_d;
      lb_q    <= lb_d;
      txthr_q <= txthr_d;
      rxthr_q <= rxthr_d;
    end
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en_q) && $stable(txthr_q) && $stable(rxthr_q)));
endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags
  import spi_evt_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_d;

    always_comb begin
      flag_d = flag_q[i];
      if (clr[i])  flag_d = 1'b0;
      if (cond[i]) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d;
    end

    // R5 R7
    flag_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond[i] |=> flag_q[i]);
    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> $past(cond[i]));
    // R6
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_evt_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_in,
  input  logic [N-1:0] flags,
  output logic [N-1:0] mask_q,
  output logic         irq_q
);
  logic [N-1:0] mask_d;
  logic         irq_d;

  always_comb begin
    mask_d = mask_wr ? mask_in : mask_q;
    irq_d  = |(flags & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  // R9
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_q);
  // R9
  irq_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |=> !irq_q);
endmodule

// File: rtl/spi_evt_irq_unit.sv
module spi_evt_irq_unit
  import spi_evt_pkg::*;
#(
  parameter int FIFO_WORDS = 8,
  parameter int THR_W      = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             reg_addr,
  input  logic                   reg_wr,
  input  logic [WORD_W-1:0]      reg_wdata,
  output logic [WORD_W-1:0]      reg_rdata,
  input  logic [FIELD_W-1:0]     rx_byte_cnt,
  input  logic [FIELD_W-1:0]     tx_byte_cnt,
  output logic                   ctrl_en,
  output logic                   loopback,
  output logic [THR_W-1:0]       tx_thresh,
  output logic [THR_W-1:0]       rx_thresh,
  output logic                   fifo_flush,
  output logic                   irq
);
  localparam int CAP_BYTES = FIFO_WORDS * 4;

  logic             wr_mode, wr_evt, wr_mask;
  logic [NFLAG-1:0] cond, clr, flags, mask_q;
  logic [FIELD_W-1:0] rx_g, tx_g;
  logic [WORD_W-1:0]  mode_word, evt_word, mask_word;

  always_comb begin
    wr_mode = reg_wr && (reg_addr == ADDR_MODE);
    wr_evt  = reg_wr && (reg_addr == ADDR_EVT);
    wr_mask = reg_wr && (reg_addr == ADDR_MASK);
  end

  spi_mode_regs #(.THR_W(THR_W), .TXTHR_RST(4), .RXTHR_RST(3)) mode_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_mode),
    .en_in    (reg_wdata[MODE_EN_BIT]),
    .lb_in    (reg_wdata[MODE_LB_BIT]),
    .txthr_in (reg_wdata[TXTHR_LSB +: THR_W]),
    .rxthr_in (reg_wdata[RXTHR_LSB +: THR_W]),
    .en_q     (ctrl_en),
    .lb_q     (loopback),
    .txthr_q  (tx_thresh),
    .rxthr_q  (rx_thresh)
  );

  always_comb begin
    fifo_flush    = !ctrl_en;
    rx_g          = ctrl_en ? rx_byte_cnt : '0;
    tx_g          = ctrl_en ? tx_byte_cnt : '0;
    cond          = '0;
    cond[FLAG_NE] = ctrl_en && (rx_byte_cnt != '0);
    cond[FLAG_NF] = ctrl_en && (int'(tx_byte_cnt) < CAP_BYTES);
    clr           = wr_evt ? reg_wdata[FLAG_LSB +: NFLAG] : '0;
  end

  spi_evt_flags #(.N(NFLAG)) flags_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond   (cond),
    .clr    (clr),
    .flag_q (flags)
  );

  spi_irq_ctrl #(.N(NFLAG)) irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_wr (wr_mask),
    .mask_in (reg_wdata[FLAG_LSB +: NFLAG]),
    .flags   (flags),
    .mask_q  (mask_q),
    .irq_q   (irq)
  );

  always_comb begin
    mode_word = '0;
    mode_word[MODE_EN_BIT] = ctrl_en;
    mode_word[MODE_LB_BIT] = loopback;
    mode_word[TXTHR_LSB +: THR_W] = tx_thresh;
    mode_word[RXTHR_LSB +: THR_W] = rx_thresh;

    evt_word = '0;
    evt_word[RXCNT_LSB +: FIELD_W] = rx_g;
    evt_word[TXCNT_LSB +: FIELD_W] = tx_g;
    evt_word[FLAG_LSB +: NFLAG]    = flags;

    mask_word = '0;
    mask_word[FLAG_LSB +: NFLAG] = mask_q;

    case (reg_addr)
      ADDR_MODE: reg_rdata = mode_word;
      ADDR_EVT:  reg_rdata = evt_word;
      ADDR_MASK: reg_rdata = mask_word;
      default:   reg_rdata = '0;
    endcase
  end

  // R4
  off_counts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && reg_addr == ADDR_EVT) |->
      (reg_rdata[RXCNT_LSB +: FIELD_W] == '0 && reg_rdata[TXCNT_LSB +: FIELD_W] == '0));
  // R3
  on_counts_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && reg_addr == ADDR_EVT) |-> (reg_rdata[RXCNT_LSB +: FIELD_W] == rx_byte_cnt));
endmodule

// File: tb/spi_evt_irq_unit_tb_top.sv
module spi_evt_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [5:0]  rx_byte_cnt, tx_byte_cnt;
  logic        ctrl_en, loopback, fifo_flush, irq;
  logic [5:0]  tx_thresh, rx_thresh;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  spi_evt_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_byte_cnt(rx_byte_cnt), .tx_byte_cnt(tx_byte_cnt),
    .ctrl_en(ctrl_en), .loopback(loopback), .tx_thresh(tx_thresh),
    .rx_thresh(rx_thresh), .fifo_flush(fifo_flush), .irq(irq)
  );

  // {en, rx count, tx count, expected event word}
  localparam logic [44:0] VEC [6] = '{
    {1'b1, 6'd0,  6'd0,  32'h0000_0100},
    {1'b1, 6'd5,  6'd32, 32'h0520_0200},
    {1'b1, 6'd32, 6'd31, 32'h201F_0300},
    {1'b0, 6'd12, 6'd3,  32'h0000_0000},
    {1'b1, 6'd1,  6'd32, 32'h0120_0200},
    {1'b1, 6'd17, 6'd1,  32'h1101_0300}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle_clear();
    wr(2'd0, 32'h0000_0403);
    wr(2'd1, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = '0;
    rx_byte_cnt = '0; tx_byte_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); check("R1 mode reset", v, 32'h0000_0403);
    rd(2'd1, v); check("R1 event reset", v, 32'h0);
    rd(2'd2, v); check("R1 mask reset", v, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    check("R4 flush at reset", {31'b0, fifo_flush}, 32'h1);

    // R3 R4 R5 vector walk
    for (int i = 0; i < 6; i++) begin
      rx_byte_cnt = VEC[i][43:38];
      tx_byte_cnt = VEC[i][37:32];
      wr(2'd0, {VEC[i][44], 31'h0000_0403});
      @(negedge clk);
      rd(2'd1, v);
      check($sformatf("R3/R4/R5 vector %0d", i), v, VEC[i][31:0]);
      idle_clear();
      rd(2'd1, v);
      check($sformatf("R6 cleared after vector %0d", i), v, 32'h0);
    end

    // R2 mode fields and outputs
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R2 mode readback", v, 32'hC000_3F3F);
    check("R2 outputs", {20'b0, ctrl_en, loopback, fifo_flush, 3'b0, tx_thresh}, 32'h0000_0C3F);
    check("R2 rx thresh", {26'b0, rx_thresh}, 32'h3F);
    wr(2'd0, 32'h4000_0A05);
    rd(2'd0, v); check("R2 mode readback 2", v, 32'h4000_0A05);
    check("R4 flush when off", {31'b0, fifo_flush}, 32'h1);
    wr(2'd1, 32'hFFFF_FFFF);

    // R8 mask
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R8 mask readback", v, 32'h0000_0300);
    wr(2'd2, 32'h0);

    // R7 W1C while live, R10 counts unaffected
    rx_byte_cnt = 6'd4; tx_byte_cnt = 6'd32;
    wr(2'd0, 32'h8000_0403);
    @(negedge clk);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R7/R10 live flag kept", v, 32'h0420_0200);
    // R6 write 0 no effect, then clear after condition gone
    rx_byte_cnt = 6'd0; tx_byte_cnt = 6'd32;
    wr(2'd1, 32'h0);
    rd(2'd1, v); check("R6 zero write no effect", v, 32'h0020_0200);
    wr(2'd1, 32'h0000_0200);
    rd(2'd1, v); check("R6 clear when false", v, 32'h0020_0000);
    rd(2'd3, v); check("R10 reserved reads 0", v, 32'h0);

    // R9 interrupt timing, mask 0 first
    rx_byte_cnt = 6'd2;
    @(negedge clk); @(negedge clk);
    check("R9 no irq with mask 0", {31'b0, irq}, 32'h0);
    rx_byte_cnt = 6'd0;
    wr(2'd1, 32'h0000_0200);
    wr(2'd2, 32'h0000_0200);
    rx_byte_cnt = 6'd2;
    @(negedge clk);
    check("R9 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq high", {31'b0, irq}, 32'h1);
    rx_byte_cnt = 6'd0;
    @(negedge clk);
    reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 32'h0000_0200;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R9 irq still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R9 irq low", {31'b0, irq}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule